// File: doc/BRIEF.md
# Clause 22 Management Frame Responder

This block is the PHY-side end of a two-wire management link that a host drives by software. The host holds a small control word (serial data out, output enable, management clock) and rewrites it to wiggle the link one bit at a time. The block watches every host write. On each rising transition of the clock bit it takes one serial bit, finds the all-ones preamble, decodes the 16-bit frame header, and then either presents a 16-bit register value on the data-in bit, most significant bit first, or captures 16 bits into its register file.

The register file holds 32 registers of 16 bits. Two of them hold fixed identifier values. The PHY address in the header is decoded but does not filter frames, so the block answers every address. The host reads the data-in bit back through the same control word it writes.

Top module: `mdio_responder`

## Requirements
- R1: After reset the readback word is 0, register 2 reads 16'h0022, register 3 reads 16'h161A and every other register reads 0.
- R2: The readback word returns written bits 3 (clock), 2 (enable) and 0 (data out) as written. Bit 1 is the responder's data-in bit, and the value written to bit 1 has no effect.
- R3: A rising clock edge shifts in a 1 only when data out (bit 0) and enable (bit 2) are both set; otherwise it shifts in a 0. A preamble driven with enable low does not start a frame.
- R4: A frame is recognised only after 32 consecutive ones have been shifted in. With only 31 ones the following header is ignored and data-in keeps its previous value.
- R5: The 16 bits after the preamble form the header: start in bits 15:14, opcode in 13:12, PHY address in 11:7, register address in 6:2 and turnaround in 1:0, with bit 15 received first. A start code other than 01, or an opcode other than 01 or 10, aborts the frame.
- R6: Opcode 01 with turnaround 10 is a write. The next 16 bits, MSB first, are stored to the addressed register, whatever the PHY address field holds.
- R7: A write header whose turnaround is not 10 stores nothing.
- R8: Opcode 10 with turnaround bit 0 clear is a read. On each of the next 16 rising edges data-in takes the next bit of the addressed register, MSB first. After the last bit it holds its value.
- R9: Writes to registers 2 and 3 are ignored.
- R10: Only a 0-to-1 change of the clock bit between consecutive host writes counts as an edge. Writes that keep the clock high move no bit and leave data-in unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the control word |
| host_wdata | input | 4 | Control word: bit3 clock, bit2 enable, bit1 ignored, bit0 data out |
| host_rdata | output | 4 | Readback: bit3 clock, bit2 enable, bit1 data-in, bit0 data out |

## Verification
The checks assume that the host changes the control word only through the write strobe, and that the reset is held for some cycles before the first write. The bench drives every serial bit as three writes: clock low, clock high, then clock still high with data and bit 1 changed. So each bit gives exactly one rising edge, plus writes that should have no effect. Read frames release the enable bit during turnaround and data, so the shifted-in turnaround is 00, as a real host would produce.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Control word bit positions (host-visible layout)
  localparam int CTL_DO  = 0;
  localparam int CTL_DI  = 1;
  localparam int CTL_OE  = 2;
  localparam int CTL_CLK = 3;
  localparam int CTL_W   = 4;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] TA_WRITE   = 2'b10;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/mdio_bit_sampler.sv
module mdio_bit_sampler
  import mdio_pkg::*;
#(
  parameter int SHIFT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CTL_W-1:0]   wdata,
  output logic               step,
  output logic [SHIFT_W-1:0] sr_next,
  output logic [CTL_W-1:0]   ctrl_q
);
  localparam logic [CTL_W-1:0] KEEP_MASK = ~(CTL_W'(1) << CTL_DI);

  logic               last_clk_q;
  logic [SHIFT_W-1:0] sr_q;
  logic               bit_in;

  always_comb begin
    step    = we && !last_clk_q && wdata[CTL_CLK];
    bit_in  = wdata[CTL_DO] & wdata[CTL_OE];
    sr_next = {sr_q[SHIFT_W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_clk_q <= 1'b0;
      sr_q       <= '0;
      ctrl_q     <= '0;
    end else begin
      if (step) sr_q <= sr_next;
      if (we) begin
        last_clk_q <= wdata[CTL_CLK];
        ctrl_q     <= wdata & KEEP_MASK;
      end
    end
  end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int SHIFT_W = 32,
  parameter int REG_W   = 16,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [SHIFT_W-1:0] sr_next,
  input  logic [REG_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [REG_W-1:0]   wr_data,
  output logic               di,
  output phase_e             phase
);
  localparam int CNT_W = $clog2(SHIFT_W) + 2;
  localparam logic signed [CNT_W-1:0] SYNC_CNT = CNT_W'(SHIFT_W);
  localparam logic signed [CNT_W-1:0] HDR_CNT  = CNT_W'(REG_W);
  localparam logic signed [CNT_W-1:0] CNT_DONE = '1;
  localparam logic signed [CNT_W-1:0] CNT_ZERO = '0;
  // header field positions inside the last 16 received bits
  localparam int RA_LO = 2;
  localparam int PA_LO = RA_LO + ADDR_W;

  logic signed [CNT_W-1:0] cnt_q, cnt_v;
  phase_e                  phase_q, phase_v;
  logic [ADDR_W-1:0]       addr_q, addr_v;
  logic [REG_W-1:0]        out_q, out_v;
  logic                    di_q, di_v;
  logic                    sync;
  logic [1:0]              hdr_start, hdr_op, hdr_ta;

  assign hdr_start = sr_next[15:14];
  assign hdr_op    = sr_next[13:12];
  assign hdr_ta    = sr_next[1:0];
  assign rd_addr   = sr_next[RA_LO +: ADDR_W];
  assign sync      = &sr_next;

  always_comb begin
    cnt_v   = sync ? SYNC_CNT : cnt_q;
    phase_v = phase_q;
    addr_v  = addr_q;
    out_v   = out_q;
    di_v    = di_q;
    wr_en   = 1'b0;
    if (step) begin
      if (cnt_v == HDR_CNT) begin
        if (hdr_start == START_CODE && hdr_op == OP_WRITE && hdr_ta == TA_WRITE)
          phase_v = PH_WRITE;
        else if (hdr_start == START_CODE && hdr_op == OP_READ && !hdr_ta[0])
          phase_v = PH_READ;
        else
          phase_v = PH_IDLE;
        if (phase_v != PH_IDLE) addr_v = rd_addr;
        if (phase_v == PH_READ) out_v = rd_data;
      end
      if (phase_v == PH_READ && cnt_v < HDR_CNT) begin
        di_v  = out_v[REG_W-1];
        out_v = {out_v[REG_W-2:0], 1'b0};
      end
      if (cnt_v == CNT_ZERO && phase_v != PH_IDLE) begin
        wr_en   = (phase_v == PH_WRITE);
        phase_v = PH_IDLE;
      end
    end
  end

  assign wr_addr = addr_v;
  assign wr_data = sr_next[REG_W-1:0];
  assign di      = di_q;
  assign phase   = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= CNT_DONE;
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      out_q   <= '0;
      di_q    <= 1'b0;
    end else if (step) begin
      cnt_q   <= (cnt_v == CNT_DONE) ? CNT_DONE : cnt_v - 1'b1;
      phase_q <= phase_v;
      addr_q  <= addr_v;
      out_q   <= out_v;
      di_q    <= di_v;
    end
  end

  // PHY address field is decoded but deliberately not used for filtering
  logic unused_phy;
  assign unused_phy = ^sr_next[PA_LO +: ADDR_W];
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int          NREG       = 32,
  parameter int          REG_W      = 16,
  parameter int          ADDR_W     = $clog2(NREG),
  parameter int          ID_HI_ADDR = 2,
  parameter int          ID_LO_ADDR = 3,
  parameter logic [15:0] ID_HI      = 16'h0022,
  parameter logic [15:0] ID_LO      = 16'h161A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == ID_HI_ADDR) begin : g_id_hi
      assign regs_q[g] = REG_W'(ID_HI);
    end else if (g == ID_LO_ADDR) begin : g_id_lo
      assign regs_q[g] = REG_W'(ID_LO);
    end else begin : g_rw
      logic [REG_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else if (we && waddr == ADDR_W'(g)) val_q <= wdata;
      end
      assign regs_q[g] = val_q;
    end
  end

  assign rdata = regs_q[raddr];
endmodule

// File: rtl/mdio_responder.sv
module mdio_responder
  import mdio_pkg::*;
#(
  parameter int          SHIFT_W    = 32,
  parameter int          NREG       = 32,
  parameter int          REG_W      = 16,
  parameter int          ID_HI_ADDR = 2,
  parameter int          ID_LO_ADDR = 3,
  parameter logic [15:0] ID_HI      = 16'h0022,
  parameter logic [15:0] ID_LO      = 16'h161A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [3:0] host_wdata,
  output logic [3:0] host_rdata
);
  localparam int ADDR_W = $clog2(NREG);

  logic               step;
  logic [SHIFT_W-1:0] sr_next;
  logic [CTL_W-1:0]   ctrl_q;
  logic [REG_W-1:0]   rd_data;
  logic [ADDR_W-1:0]  rd_addr;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [REG_W-1:0]   wr_data;
  logic               di;
  phase_e             phase;

  mdio_bit_sampler #(.SHIFT_W(SHIFT_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .we(host_we), .wdata(host_wdata),
    .step(step), .sr_next(sr_next), .ctrl_q(ctrl_q)
  );

  mdio_frame_ctrl #(.SHIFT_W(SHIFT_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .step(step), .sr_next(sr_next),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .di(di), .phase(phase)
  );

  mdio_regfile #(
    .NREG(NREG), .REG_W(REG_W), .ADDR_W(ADDR_W),
    .ID_HI_ADDR(ID_HI_ADDR), .ID_LO_ADDR(ID_LO_ADDR),
    .ID_HI(ID_HI), .ID_LO(ID_LO)
  ) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr),
    .wdata(wr_data), .raddr(rd_addr), .rdata(rd_data)
  );

  always_comb begin
    host_rdata         = ctrl_q;
    host_rdata[CTL_DI] = di;
  end
endmodule

// File: rtl/mdio_responder_chk.sv
module mdio_responder_chk
  import mdio_pkg::*;
#(
  parameter int          ADDR_W     = 5,
  parameter int          REG_W      = 16,
  parameter int          ID_HI_ADDR = 2,
  parameter int          ID_LO_ADDR = 3,
  parameter logic [15:0] ID_HI      = 16'h0022,
  parameter logic [15:0] ID_LO      = 16'h161A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        host_rdata,
  input logic              step,
  input logic              di,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [REG_W-1:0]  rd_data,
  input phase_e            phase
);
  AST_RESET_CLEARS_READBACK: assert property (@(posedge clk)
    !rst_n |=> host_rdata == 4'b0000); // R1

  AST_DI_HOLDS_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(di)); // R10

  AST_WRITE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> step); // R6

  AST_WRITE_ONLY_IN_WRITE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> phase == PH_WRITE); // R6

  AST_ID_HI_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == ADDR_W'(ID_HI_ADDR) |-> rd_data == REG_W'(ID_HI)); // R9

  AST_ID_LO_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == ADDR_W'(ID_LO_ADDR) |-> rd_data == REG_W'(ID_LO)); // R9
endmodule

bind mdio_responder mdio_responder_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .ID_HI_ADDR(ID_HI_ADDR),
  .ID_LO_ADDR(ID_LO_ADDR), .ID_HI(ID_HI), .ID_LO(ID_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rdata(host_rdata), .step(step), .di(di),
  .wr_en(wr_en), .rd_addr(rd_addr), .rd_data(rd_data), .phase(phase)
);

// File: tb/sim_mdio_responder.sv
`timescale 1ns/1ps
module sim_mdio_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [3:0] host_wdata = 4'b0000;
  logic [3:0] host_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        cap_req = 1'b0;
  logic [15:0] cap_word = '0;
  int          cap_bits = 0;

  always #5 clk = ~clk;

  mdio_responder u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: collects 16 data-in samples and compares against the scoreboard
  always @(negedge clk) begin
    if (cap_req) begin
      cap_word = {cap_word[14:0], host_rdata[1]};
      cap_bits++;
      if (cap_bits == 16) begin
        cap_bits = 0;
        if (exp_q.size() == 0) begin
          check("R8 unexpected read data", cap_word, 16'hxxxx);
        end else begin
          check(tag_q.pop_front(), cap_word, exp_q.pop_front());
        end
      end
    end
  end

  task automatic host_write(input logic [3:0] v);
    @(negedge clk);
    host_we    = 1'b1;
    host_wdata = v;
    @(negedge clk);
    host_we    = 1'b0;
  endtask

  // one serial bit: clock low, clock high, then clock held high with
  // flipped data and bit 1 set, which must move nothing (R10, R2)
  task automatic drive_bit(input logic d, input logic oe, input logic cap);
    host_write({1'b0, oe, 1'b0, d});
    host_write({1'b1, oe, 1'b0, d});
    host_write({1'b1, oe, 1'b1, ~d});
    if (cap) begin
      cap_req <= 1'b1;
      @(negedge clk);
      cap_req <= 1'b0;
    end
  endtask

  task automatic frame(input int npre, input logic oe_pre, input logic [1:0] st,
                       input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [1:0] ta,
                       input logic [15:0] data, input logic is_rd);
    logic [13:0] hdr;
    hdr = {st, op, phy, ra};
    for (int i = 0; i < npre; i++) drive_bit(1'b1, oe_pre, 1'b0);
    for (int i = 13; i >= 0; i--) drive_bit(hdr[i], 1'b1, 1'b0);
    for (int i = 1; i >= 0; i--) drive_bit(ta[i], !is_rd, 1'b0);
    for (int i = 15; i >= 0; i--) begin
      if (is_rd) drive_bit(1'b0, 1'b0, 1'b1);
      else       drive_bit(data[i], 1'b1, 1'b0);
    end
  endtask

  task automatic wr(input logic [4:0] ra, input logic [15:0] d, input logic [4:0] phy);
    frame(32, 1'b1, 2'b01, 2'b01, phy, ra, 2'b10, d, 1'b0);
  endtask

  task automatic rd(input logic [4:0] ra, input logic [15:0] exp, input string tag,
                    input int npre);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    frame(npre, 1'b1, 2'b01, 2'b10, 5'd0, ra, 2'b00, 16'h0000, 1'b1);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 readback after reset", {12'h0, host_rdata}, 16'h0000);
    host_write(4'b0010);
    check("R2 bit1 write ignored", {12'h0, host_rdata}, 16'h0000);
    host_write(4'b1101);
    check("R2 readback of written bits", {12'h0, host_rdata}, 16'h000D);
    host_write(4'b0000);

    rd(5'd2, 16'h0022, "R1 reg2 default", 32);
    rd(5'd3, 16'h161A, "R1 reg3 default", 32);
    rd(5'd0, 16'h0000, "R1 reg0 default", 32);

    wr(5'd5, 16'hA5C3, 5'd0);
    rd(5'd5, 16'hA5C3, "R6 R8 write then read reg5", 32);
    // last bit was 1; a 31-one preamble must leave data-in stuck at 1
    rd(5'd3, 16'hFFFF, "R4 short preamble ignored", 31);

    wr(5'd9, 16'h3C5A, 5'd7);
    rd(5'd9, 16'h3C5A, "R6 PHY address not filtered", 32);

    frame(32, 1'b1, 2'b01, 2'b01, 5'd0, 5'd10, 2'b00, 16'h1234, 1'b0);
    rd(5'd10, 16'h0000, "R7 bad turnaround write dropped", 32);

    frame(32, 1'b1, 2'b11, 2'b01, 5'd0, 5'd11, 2'b10, 16'h4321, 1'b0);
    rd(5'd11, 16'h0000, "R5 bad start code", 32);

    frame(32, 1'b1, 2'b01, 2'b11, 5'd0, 5'd13, 2'b10, 16'h7777, 1'b0);
    rd(5'd13, 16'h0000, "R5 bad opcode", 32);

    wr(5'd2, 16'hFFFF, 5'd0);
    rd(5'd2, 16'h0022, "R9 reg2 write ignored", 32);
    wr(5'd3, 16'h0000, 5'd0);
    rd(5'd3, 16'h161A, "R9 reg3 write ignored", 32);

    frame(32, 1'b0, 2'b01, 2'b01, 5'd0, 5'd12, 2'b10, 16'hBEEF, 1'b0);
    rd(5'd12, 16'h0000, "R3 preamble with enable low", 32);

    wr(5'd31, 16'hFFFF, 5'd0);
    rd(5'd31, 16'hFFFF, "R8 all ones register", 32);
    wr(5'd1, 16'h0001, 5'd0);
    rd(5'd1, 16'h0001, "R8 MSB first order", 32);

    repeat (4) @(negedge clk);
    check("R8 scoreboard drained", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule